// File: doc/BRIEF.md
# Multi-Mode Serial Receive Engine

This block turns a serial input line into parallel words. It runs in two ways. In asynchronous framed operation it finds a start bit and takes 7, 8 or 9 data bits, an optional parity bit and one or two stop bits. In clocked operation it shifts in 8 bits on a chosen edge of an external transfer clock. A small set of run-time control inputs selects the operating style, word length, bit order, line inversion, parity sense, stop count and clock edge. The encoding of these inputs matches the one the companion transmitter uses.

Asynchronous reception is timed by a tick that runs at sixteen times the bit rate. A completed word appears on a 9-bit output together with a one-cycle valid strobe and three error flags. The flags stay valid until the next word arrives. The consumer acknowledges each word with a read strobe. A ready-to-send output, when selected, tells the far end whether a word is still waiting to be read.

Top module: `sio_rx`

## Requirements
- R1: After reset the data output and all three error flags are 0, the valid strobe is low, and the ready output is 1 when handshaking and the ready function are both selected.
- R2: With mode 101, an 8-bit frame is received LSB first. A start is detected on a high-to-low transition seen at a tick and is confirmed low 8 ticks later. Each following bit is sampled 16 ticks after the previous sample. The valid strobe is high for exactly one cycle per word.
- R3: Modes 100 and 110 take 7 and 9 data bits, always LSB first whatever the bit-order input says. Unused upper output bits read 0.
- R4: When the bit-order input is 1 in mode 101 or in mode 001, the first received bit becomes bit 7 of the word.
- R5: When parity is enabled, the bit after the data is checked. With parity select 1, the data bits and the parity bit together must hold an even number of ones. With select 0 they must hold an odd number. A mismatch sets the parity error flag.
- R6: When the stop-count input is 0, one stop bit is sampled. When it is 1, two stop bits are sampled. Any stop bit sampled low sets the framing error flag.
- R7: A low pulse that is high again at the confirmation tick (tick 8) is discarded and produces no word.
- R8: When the inversion input is 1, the line is complemented before any decoding, in both operating styles.
- R9: Mode 001 samples the line on the rising transfer-clock edge when polarity is 0 and on the falling edge when polarity is 1. It delivers a word every 8 sampled bits, with the parity and framing flags at 0.
- R10: If a word completes while the previous word is unread, the overrun flag of the new word is 1. A read strobe in the same cycle as completion counts as reading in time.
- R11: When handshaking is enabled and the ready function is selected, the ready output is 0 from the cycle a word is delivered until the cycle after it is read. Otherwise the output is 0.
- R12: With mode 000 no word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial data line |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| sclk_in | input | 1 | Transfer clock for mode 001, synchronous to clk |
| mode | input | 3 | 000 off, 001 clocked, 100/101/110 framed with 7/8/9 bits |
| clk_pol | input | 1 | 0 rising-edge sampling, 1 falling-edge sampling |
| line_inv | input | 1 | Complement the serial line |
| par_en | input | 1 | Expect a parity bit |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| two_stop | input | 1 | Expect two stop bits |
| msb_first | input | 1 | MSB-first assembly where the mode allows it |
| hs_en | input | 1 | Enable the handshake function |
| rts_sel | input | 1 | Select the ready output function |
| rd_ack | input | 1 | Consumer has read the held word |
| data_out | output | 9 | Last received word |
| data_valid | output | 1 | One-cycle strobe for a new word |
| err_parity | output | 1 | Parity mismatch in the last word |
| err_frame | output | 1 | Stop bit sampled low in the last word |
| err_overrun | output | 1 | Last word overwrote an unread one |
| rts_ready | output | 1 | Ready to accept more data |

## Verification
Some faults inside the block only show at the ports. A bad tick count or mid-bit point shifts the sampling instant, and this shows as bit slips in `data_out` once a frame ends. A stuck state register shows as a missing or extra valid strobe before the next frame could complete. A bad holding flag shows up in the same cycle as a wrong `rts_ready` level or a wrong overrun flag on the next delivered word. Inverted or mis-indexed bit placement appears as soon as the first word is delivered.

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       os_tick,
  input  logic       sclk_in,
  input  logic [2:0] mode,
  input  logic       clk_pol,
  input  logic       line_inv,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  input  logic       msb_first,
  input  logic       hs_en,
  input  logic       rts_sel,
  input  logic       rd_ack,
  output logic [8:0] data_out,
  output logic       data_valid,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       rts_ready
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [3:0]     bidx;
  logic [8:0]     shreg, nxt_sh;
  logic           par_acc, perr, ferr, stop2, rx_last, sclk_q, full;
  logic [3:0]     nbits, pos;

  wire rxd     = rx_in ^ line_inv;
  wire sync_m  = (mode == 3'b001);
  wire uart_m  = mode[2] && (mode[1:0] != 2'b11);
  wire msb_eff = msb_first && (sync_m || mode == 3'b101);
  wire hit     = os_tick && (cnt == LAST);
  wire s_edge  = sync_m && (clk_pol ? (sclk_q && !sclk_in) : (!sclk_q && sclk_in));
  wire s_fin   = s_edge && (bidx == 4'd7);
  wire u_fin   = uart_m && hit && (st == S_STOP) && !(two_stop && !stop2);
  wire fin     = s_fin || u_fin;

  always_comb begin
    case (mode[1:0])
      2'b00:   nbits = 4'd7;
      2'b10:   nbits = 4'd9;
      default: nbits = 4'd8;
    endcase
    if (sync_m) nbits = 4'd8;
  end

  assign pos = msb_eff ? 4'd7 - bidx : bidx;

  always_comb begin
    nxt_sh = shreg;
    nxt_sh[pos] = rxd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; shreg <= '0;
      par_acc <= 1'b0; perr <= 1'b0; ferr <= 1'b0; stop2 <= 1'b0;
      rx_last <= 1'b1; sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_in;
      if (!(uart_m || sync_m)) begin
        st <= S_IDLE; bidx <= '0; rx_last <= 1'b1;
      end else if (sync_m) begin
        st <= S_IDLE; rx_last <= 1'b1;
        if (s_edge) begin
          shreg <= nxt_sh;
          bidx  <= s_fin ? 4'd0 : bidx + 4'd1;
        end
      end else if (os_tick) begin
        rx_last <= rxd;
        case (st)
          S_IDLE:
            if (rx_last && !rxd) begin st <= S_START; cnt <= '0; end
          S_START:
            if (cnt == HALF) begin
              cnt <= '0;
              if (!rxd) begin
                st <= S_DATA; bidx <= '0; shreg <= '0;
                par_acc <= 1'b0; perr <= 1'b0; ferr <= 1'b0; stop2 <= 1'b0;
              end else st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (hit) begin
              cnt     <= '0;
              shreg   <= nxt_sh;
              par_acc <= par_acc ^ rxd;
              if (bidx == nbits - 4'd1) st <= par_en ? S_PAR : S_STOP;
              else bidx <= bidx + 4'd1;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (hit) begin
              cnt  <= '0;
              perr <= ((par_acc ^ rxd) == par_even);
              st   <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (hit) begin
              cnt <= '0;
              if (!rxd) ferr <= 1'b1;
              if (two_stop && !stop2) stop2 <= 1'b1;
              else begin st <= S_IDLE; bidx <= '0; end
            end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0; data_valid <= 1'b0; full <= 1'b0;
      err_parity <= 1'b0; err_frame <= 1'b0; err_overrun <= 1'b0;
    end else if (fin) begin
      data_out    <= s_fin ? {1'b0, nxt_sh[7:0]} : shreg;
      err_parity  <= s_fin ? 1'b0 : perr;
      err_frame   <= s_fin ? 1'b0 : (ferr || !rxd);
      err_overrun <= full && !rd_ack;
      data_valid  <= 1'b1;
      full        <= 1'b1;
    end else begin
      data_valid <= 1'b0;
      if (rd_ack) full <= 1'b0;
    end
  end

  assign rts_ready = hs_en && rts_sel && !full;
endmodule

// File: rtl/sio_rx_chk.sv
module sio_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       hs_en,
  input logic       rts_sel,
  input logic       rd_ack,
  input logic       data_valid,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_overrun,
  input logic       rts_ready
);
  logic unread;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) unread <= 1'b0;
    else        unread <= (unread || data_valid) && !rd_ack;

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000) |=> !data_valid);

  assert_sync_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $past(mode) == 3'b001) |-> (!err_parity && !err_frame));

  assert_overrun_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (err_overrun == unread));

  assert_ready_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && rts_sel) |-> (rts_ready == !(unread || data_valid)));
endmodule

bind sio_rx sio_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .hs_en(hs_en), .rts_sel(rts_sel),
  .rd_ack(rd_ack), .data_valid(data_valid), .err_parity(err_parity),
  .err_frame(err_frame), .err_overrun(err_overrun), .rts_ready(rts_ready)
);

// File: tb/sio_rx_tb.sv
module sio_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 32;

  logic clk = 0, rst_n = 0;
  logic rx_in = 1, os_tick = 0, sclk_in = 0;
  logic [2:0] mode = 3'b000;
  logic clk_pol = 0, line_inv = 0, par_en = 0, par_even = 0, two_stop = 0;
  logic msb_first = 0, hs_en = 1, rts_sel = 1, rd_ack = 0;
  logic [8:0] data_out;
  logic data_valid, err_parity, err_frame, err_overrun, rts_ready;

  int tests = 0, fails = 0, nvalid = 0;
  bit done = 0;

  sio_rx u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) begin
    os_tick <= ~os_tick;
    if (data_valid) nvalid <= nvalid + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic b);
    rx_in = b ^ line_inv;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send_uart(input logic [8:0] d, input int n, input bit msb, input bit pbit,
                           input bit s1, input bit s2);
    drive(1'b0);
    for (int i = 0; i < n; i++) drive(msb ? d[n-1-i] : d[i]);
    if (par_en) drive(pbit);
    drive(s1);
    if (two_stop) drive(s2);
    rx_in = 1'b1 ^ line_inv;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_sync(input logic [7:0] d, input bit msb);
    for (int i = 0; i < 8; i++) begin
      rx_in = (msb ? d[7-i] : d[i]) ^ line_inv;
      repeat (2) @(negedge clk);
      sclk_in = ~sclk_in;
      repeat (2) @(negedge clk);
      rx_in = ~rx_in;
      sclk_in = ~sclk_in;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic ack();
    rd_ack = 1; @(negedge clk); rd_ack = 0; @(negedge clk);
  endtask

  task automatic setup(input logic [2:0] m);
    mode = 3'b000; repeat (2) @(negedge clk);
    rx_in = 1'b1 ^ line_inv;
    mode = m; repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 data", data_out, 0);
    chk("R1 flags", {err_parity, err_frame, err_overrun, data_valid}, 0);
    chk("R1 ready", rts_ready, 1);
  endtask

  task automatic t_uart8();
    int n0;
    setup(3'b101); n0 = nvalid;
    send_uart(9'h0A5, 8, 0, 0, 1, 1);
    chk("R2 data", data_out, 9'h0A5);
    chk("R2 one strobe", nvalid - n0, 1);
    chk("R2 flags", {err_parity, err_frame, err_overrun}, 0);
    ack();
  endtask

  task automatic t_len();
    setup(3'b100); msb_first = 1;
    send_uart(9'h05B, 7, 0, 0, 1, 1);
    chk("R3 seven bit", data_out, 9'h05B); ack();
    setup(3'b110);
    send_uart(9'h1C3, 9, 0, 0, 1, 1);
    chk("R3 nine bit", data_out, 9'h1C3); ack();
    msb_first = 0;
  endtask

  task automatic t_msb();
    setup(3'b101); msb_first = 1;
    send_uart(9'h01D, 8, 1, 0, 1, 1);
    chk("R4 msb first uart", data_out, 9'h01D); ack();
    msb_first = 0;
  endtask

  task automatic t_parity();
    setup(3'b101); par_en = 1; par_even = 1;
    send_uart(9'h05A, 8, 0, 0, 1, 1);
    chk("R5 even ok", {data_out, err_parity}, {9'h05A, 1'b0}); ack();
    send_uart(9'h05A, 8, 0, 1, 1, 1);
    chk("R5 even bad", err_parity, 1); ack();
    par_even = 0;
    send_uart(9'h007, 8, 0, 0, 1, 1);
    chk("R5 odd ok", err_parity, 0); ack();
    send_uart(9'h007, 8, 0, 1, 1, 1);
    chk("R5 odd bad", err_parity, 1); ack();
    par_en = 0;
  endtask

  task automatic t_stop();
    setup(3'b101);
    send_uart(9'h033, 8, 0, 0, 0, 1);
    chk("R6 one stop low", {data_out, err_frame}, {9'h033, 1'b1}); ack();
    two_stop = 1;
    send_uart(9'h044, 8, 0, 0, 1, 0);
    chk("R6 second stop low", {data_out, err_frame}, {9'h044, 1'b1}); ack();
    send_uart(9'h055, 8, 0, 0, 1, 1);
    chk("R6 two stops good", {data_out, err_frame}, {9'h055, 1'b0}); ack();
    two_stop = 0;
  endtask

  task automatic t_glitch();
    int n0;
    setup(3'b101); n0 = nvalid;
    rx_in = 0; repeat (8) @(negedge clk);
    rx_in = 1; repeat (BITC * 12) @(negedge clk);
    chk("R7 glitch ignored", nvalid - n0, 0);
  endtask

  task automatic t_inv();
    line_inv = 1; setup(3'b101);
    send_uart(9'h069, 8, 0, 0, 1, 1);
    chk("R8 inverted uart", {data_out, err_frame}, {9'h069, 1'b0}); ack();
    line_inv = 0; setup(3'b000);
  endtask

  task automatic t_sync();
    int n0;
    clk_pol = 0; sclk_in = 0; setup(3'b001); n0 = nvalid;
    send_sync(8'hB4, 0);
    chk("R9 rising", data_out, 9'h0B4);
    chk("R9 strobe", nvalid - n0, 1);
    chk("R9 flags", {err_parity, err_frame}, 0); ack();
    mode = 3'b000; clk_pol = 1; sclk_in = 1; setup(3'b001);
    send_sync(8'h2E, 0);
    chk("R9 falling", data_out, 9'h02E); ack();
    msb_first = 1;
    send_sync(8'hC1, 1);
    chk("R4 msb first sync", data_out, 9'h0C1); ack();
    msb_first = 0; line_inv = 1;
    send_sync(8'h96, 0);
    chk("R8 inverted sync", data_out, 9'h096); ack();
    line_inv = 0; setup(3'b000);
  endtask

  task automatic t_overrun();
    setup(3'b101);
    send_uart(9'h011, 8, 0, 0, 1, 1);
    chk("R10 first clean", err_overrun, 0);
    send_uart(9'h022, 8, 0, 0, 1, 1);
    chk("R10 overrun", {data_out, err_overrun}, {9'h022, 1'b1});
    ack();
    send_uart(9'h033, 8, 0, 0, 1, 1);
    chk("R10 cleared after read", err_overrun, 0);
    ack();
  endtask

  task automatic t_rts();
    setup(3'b101); hs_en = 1; rts_sel = 1;
    chk("R11 ready idle", rts_ready, 1);
    send_uart(9'h0F0, 8, 0, 0, 1, 1);
    chk("R11 held word", rts_ready, 0);
    ack();
    chk("R11 after read", rts_ready, 1);
    rts_sel = 0; @(negedge clk);
    chk("R11 not selected", rts_ready, 0);
    rts_sel = 1;
  endtask

  task automatic t_disabled();
    int n0;
    setup(3'b000); n0 = nvalid;
    send_uart(9'h0AA, 8, 0, 0, 1, 1);
    chk("R12 disabled", nvalid - n0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_uart8();
    t_len();
    t_msb();
    t_parity();
    t_stop();
    t_glitch();
    t_inv();
    t_sync();
    t_overrun();
    t_rts();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule